// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives a pair of complementary reset outputs for a host microcontroller. Three conditions hold the host in reset. The first is a supply-good flag from an external comparator, which is filtered against short glitches. The second is an active-high external reset request. The third is a watchdog that expires when the host stops toggling its serial chip-select line. Once every source is quiet, reset stays asserted for a fixed release timeout and then drops.

The block runs on a slow timebase clock, and every delay is a parameter counted in ticks of that clock. The host services the watchdog by moving chip select in either direction. A 2-bit code, normally taken from a nonvolatile status register, selects one of three watchdog periods or switches the watchdog off. While reset is asserted, the watchdog is held cleared, so the host always gets a full period after each reset.

Top module: `rst_supervisor`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, reset_o is 1 and reset_no is 0.
- R2: After the synchronized and filtered supply flag goes good, reset_o stays 1 for RST_TICKS more cycles. From a clean rise of vcc_ok_i, reset_o falls 2+GLITCH_TICKS+RST_TICKS cycles later.
- R3: vcc_ok_i held low for longer than GLITCH_TICKS cycles asserts reset_o within SYNC_STAGES+GLITCH_TICKS+1 cycles, and reset_o stays 1 for as long as it remains low.
- R4: A low pulse on vcc_ok_i that lasts fewer than GLITCH_TICKS cycles has no effect on reset_o.
- R5: ext_rst_i is active high. While it is high, reset_o is 1 (after a two-flop synchronizer). reset_o falls about RST_TICKS+2 cycles after ext_rst_i is released.
- R6: wd_sel_i sets the watchdog period: 2'b00 gives WD_TICKS_LONG, 2'b01 gives WD_TICKS_MID, 2'b10 gives WD_TICKS_SHORT, and 2'b11 turns the watchdog off. On expiry, reset_o is 1 for RST_TICKS cycles.
- R7: Each rising edge and each falling edge of cs_i restarts the watchdog count. Edges spaced closer than the period prevent any watchdog reset.
- R8: While reset_o is 1, the watchdog count is held at zero, so a full period passes after every reset release.
- R9: Any change of wd_sel_i restarts the watchdog count from zero.
- R10: reset_no is always the inverse of reset_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_ok_i | input | 1 | Supply-good flag from the comparator (asynchronous) |
| cs_i | input | 1 | Serial chip select; its edges service the watchdog |
| ext_rst_i | input | 1 | External reset request, active high (asynchronous) |
| wd_sel_i | input | 2 | Watchdog period code |
| reset_o | output | 1 | Reset output, active high |
| reset_no | output | 1 | Reset output, active low |

## Verification
The watchdog is driven with each of the four period codes and a static chip select. The measured time to expiry separates the three periods, and the off code shows that no reset occurs. Chip select is then toggled at a spacing longer than half the short period but shorter than the whole period, followed by random spacings. This spacing tells apart a design that counts both edges from one that counts only rising edges. Supply pulses just under and well over the filter width separate filtering from pass-through. A period-code change made late in a long period shows whether the count restarts or carries over.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;
endpackage

// File: rtl/rst_sup_sync.sv
module rst_sup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/rst_sup_filt.sv
// A change of level is accepted only after it persists for TICKS consecutive cycles.
module rst_sup_filt #(
  parameter int TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(TICKS - 1)) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/rst_sup_wdog.sv
module rst_sup_wdog
  import rst_sup_pkg::*;
#(
  parameter int WD_TICKS_LONG  = 1400,
  parameter int WD_TICKS_MID   = 600,
  parameter int WD_TICKS_SHORT = 200,
  localparam int CW = $clog2(WD_TICKS_LONG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [1:0]    sel_i,
  input  logic          hold_i,
  output logic          kick_o,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  logic          cs_q;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          off, clr;

  always_comb begin
    off = 1'b0;
    unique case (wd_code_e'(sel_i))
      WD_LONG:  lim = CW'(WD_TICKS_LONG);
      WD_MID:   lim = CW'(WD_TICKS_MID);
      WD_SHORT: lim = CW'(WD_TICKS_SHORT);
      default: begin
        lim = CW'(WD_TICKS_LONG);
        off = 1'b1;
      end
    endcase
  end

  assign kick_o   = cs_i ^ cs_q;
  assign clr      = hold_i | off | kick_o | (sel_i != sel_q);
  assign expire_o = !clr && (cnt_q == lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b0;
      sel_q <= WD_OFF;
      cnt_q <= '0;
    end else begin
      cs_q  <= cs_i;
      sel_q <= sel_i;
      if (clr || expire_o) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rst_sup_rtmr.sv
module rst_sup_rtmr #(
  parameter int RST_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_good_i,
  input  logic ext_i,
  input  logic wd_expire_i,
  output logic reset_o
);
  localparam int CW = (RST_TICKS < 2) ? 1 : $clog2(RST_TICKS);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (!vcc_good_i || ext_i || wd_expire_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == CW'(RST_TICKS - 1)) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign reset_o = act_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int SYNC_STAGES    = 2,
  parameter int GLITCH_TICKS   = 4,
  parameter int RST_TICKS      = 200,
  parameter int WD_TICKS_LONG  = 1400,
  parameter int WD_TICKS_MID   = 600,
  parameter int WD_TICKS_SHORT = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vcc_ok_i,
  input  logic       cs_i,
  input  logic       ext_rst_i,
  input  logic [1:0] wd_sel_i,
  output logic       reset_o,
  output logic       reset_no
);
  localparam int WD_CW = $clog2(WD_TICKS_LONG + 1);

  logic [2:0]       sync_q;
  logic             vcc_sync, cs_sync, ext_sync;
  logic             vcc_good;
  logic             wd_kick, wd_expire;
  logic [WD_CW-1:0] wd_cnt;
  logic             rst_act;

  rst_sup_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_rst_i, cs_i, vcc_ok_i}),
    .q_o   (sync_q)
  );
  assign {ext_sync, cs_sync, vcc_sync} = sync_q;

  rst_sup_filt #(.TICKS(GLITCH_TICKS)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (vcc_sync),
    .q_o   (vcc_good)
  );

  rst_sup_wdog #(
    .WD_TICKS_LONG (WD_TICKS_LONG),
    .WD_TICKS_MID  (WD_TICKS_MID),
    .WD_TICKS_SHORT(WD_TICKS_SHORT)
  ) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (cs_sync),
    .sel_i   (wd_sel_i),
    .hold_i  (rst_act),
    .kick_o  (wd_kick),
    .expire_o(wd_expire),
    .cnt_o   (wd_cnt)
  );

  rst_sup_rtmr #(.RST_TICKS(RST_TICKS)) u_rtmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vcc_good_i (vcc_good),
    .ext_i      (ext_sync),
    .wd_expire_i(wd_expire),
    .reset_o    (rst_act)
  );

  assign reset_o  = rst_act;
  assign reset_no = ~rst_act;
endmodule

// File: rtl/rst_sup_chk.sv
module rst_sup_chk #(
  parameter int CW      = 11,
  parameter int LIM_MAX = 1400
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reset_o,
  input logic          reset_no,
  input logic          vcc_good,
  input logic          ext_sync,
  input logic          wd_kick,
  input logic [1:0]    wd_sel_i,
  input logic [CW-1:0] wd_cnt
);
  p_compl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_no == !reset_o);
  p_vcc_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_good |=> reset_o);
  p_ext_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sync |=> reset_o);
  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_o |=> wd_cnt == '0);
  p_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_sel_i == 2'b11 |=> wd_cnt == '0);
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_cnt < CW'(LIM_MAX));
  p_kick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_kick |=> wd_cnt == '0);
  p_sel_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_sel_i != $past(wd_sel_i) |=> wd_cnt == '0);
  p_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_o) |-> $past(vcc_good) && !$past(ext_sync));
endmodule

bind rst_supervisor rst_sup_chk #(.CW(WD_CW), .LIM_MAX(WD_TICKS_LONG)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .reset_o (reset_o),
  .reset_no(reset_no),
  .vcc_good(vcc_good),
  .ext_sync(ext_sync),
  .wd_kick (wd_kick),
  .wd_sel_i(wd_sel_i),
  .wd_cnt  (wd_cnt)
);

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int G  = 4;
  localparam int R  = 50;
  localparam int WL = 700;
  localparam int WM = 300;
  localparam int WS = 100;
  localparam int TOL = 3;

  logic clk = 1'b0, rst_ni = 1'b0, vcc_ok = 1'b0, cs = 1'b1, ext = 1'b0;
  logic [1:0] sel = 2'b11;
  logic reset_o, reset_no;
  int checks = 0, errors = 0, compl_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_supervisor #(
    .SYNC_STAGES(2), .GLITCH_TICKS(G), .RST_TICKS(R),
    .WD_TICKS_LONG(WL), .WD_TICKS_MID(WM), .WD_TICKS_SHORT(WS)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .vcc_ok_i(vcc_ok), .cs_i(cs),
    .ext_rst_i(ext), .wd_sel_i(sel), .reset_o(reset_o), .reset_no(reset_no)
  );

  always @(negedge clk) if (reset_no !== ~reset_o) compl_err++;

  function automatic int period_of(input logic [1:0] c);
    case (c)
      2'b00:   return WL;
      2'b01:   return WM;
      2'b10:   return WS;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_for(input logic lvl, input int maxc, output int n);
    n = 0;
    while (n < maxc) begin
      @(negedge clk);
      n++;
      if (reset_o == lvl) break;
    end
  endtask

  task automatic idle(input int cyc, output bit seen);
    seen = 1'b0;
    repeat (cyc) begin
      @(negedge clk);
      if (reset_o) seen = 1'b1;
    end
  endtask

  function automatic bit near(input int a, input int e);
    return (a >= e - TOL) && (a <= e + TOL);
  endfunction

  initial begin
    int n, seed;
    bit seen;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk(reset_o === 1'b1 && reset_no === 1'b0, "R1", int'(reset_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(reset_o === 1'b1, "R1", int'(reset_o), 1);

    vcc_ok = 1'b1;
    wait_for(1'b0, 500, n);
    chk(near(n, 2 + G + R), "R2", n, 2 + G + R);

    idle(2000, seen);
    chk(!seen, "R6 off code", int'(seen), 0);

    vcc_ok = 1'b0;
    repeat (G - 1) @(negedge clk);
    vcc_ok = 1'b1;
    idle(100, seen);
    chk(!seen, "R4", int'(seen), 0);

    vcc_ok = 1'b0;
    wait_for(1'b1, 40, n);
    chk(n <= 2 + G + 1, "R3 assert", n, 2 + G + 1);
    repeat (30) @(negedge clk);
    chk(reset_o === 1'b1, "R3 hold", int'(reset_o), 1);
    vcc_ok = 1'b1;
    wait_for(1'b0, 500, n);
    chk(near(n, 2 + G + R), "R2 re-release", n, 2 + G + R);

    ext = 1'b1;
    wait_for(1'b1, 20, n);
    chk(n <= 4, "R5 assert", n, 3);
    repeat (30) @(negedge clk);
    chk(reset_o === 1'b1, "R5 hold", int'(reset_o), 1);
    ext = 1'b0;
    wait_for(1'b0, 500, n);
    chk(near(n, R + 2), "R5 release", n, R + 2);

    for (int c = 2; c >= 0; c--) begin
      int p;
      sel = 2'(c);
      p = period_of(2'(c));
      wait_for(1'b0, 500, n);
      wait_for(1'b1, 3 * p, n);
      chk(near(n, p), "R6 period", n, p);
      wait_for(1'b0, 500, n);
      chk(near(n, R), "R6 reset width", n, R);
      wait_for(1'b1, 3 * p, n);
      chk(near(n, p), "R8 period after reset", n, p);
    end
    sel = 2'b11;
    wait_for(1'b0, 500, n);

    sel = 2'b10;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      bit s;
      cs = ~cs;
      idle(70, s);
      seen |= s;
    end
    chk(!seen, "R7 both edges", int'(seen), 0);
    seen = 1'b0;
    for (int k = 0; k < 30; k++) begin
      bit s;
      cs = ~cs;
      idle($urandom_range(85, 10), s);
      seen |= s;
    end
    chk(!seen, "R7 random kicks", int'(seen), 0);

    sel = 2'b00;
    idle(400, seen);
    chk(!seen, "R9 before change", int'(seen), 0);
    sel = 2'b10;
    wait_for(1'b1, 3 * WS, n);
    chk(near(n, WS + 1), "R9 restart", n, WS + 1);
    sel = 2'b11;
    wait_for(1'b0, 500, n);

    chk(compl_err == 0, "R10", compl_err, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule